// File: doc/BRIEF.md
# 32-bit Integer ALU with Four-Bit Operation Select

This block is the arithmetic and logic core of a small load/store processor datapath. It is purely combinational. Two 32-bit operands `a` and `b` and a 4-bit operation code produce a 32-bit result `r`, plus four status flags. The flags are zero, carry/borrow, negative and signed overflow. Instruction decoding happens upstream, and that decoder drives `op` directly.

The operand roles are not symmetric for two groups of operations. For shifts, `b` is the data being shifted and `a[4:0]` gives the distance. Upper-immediate formation uses only `b`. Signed overflow is reported for the trapping add and subtract codes, but the result is always produced. Any decision to trap belongs to the surrounding pipeline.

The block has no storage, so it has no states. Each output is a fixed function of the current inputs. One shared adder serves add, subtract and both less-than comparisons. A five-stage shift network serves the three shifts, and a small logic unit serves the four bitwise operations.

Top module: `int_alu`

## Requirements
- R1: Code 0000 (unsigned add) and code 0010 (signed add) both give r = a + b modulo 2^32.
- R2: Code 0001 (unsigned subtract) and code 0011 (signed subtract) both give r = a - b modulo 2^32.
- R3: `overflow` is 1 only for codes 0010 and 0011, and only when the true signed result does not fit in 32 bits. The wrapped result still appears on `r`.
- R4: Codes 0100, 0101, 0110 and 0111 give a AND b, a OR b, a XOR b and NOT(a OR b), in that order.
- R5: Code 1011 gives r = 1 when a < b as two's-complement numbers and r = 0 otherwise. This holds for the extreme values 0x80000000 and 0x7FFFFFFF.
- R6: Code 1010 gives r = 1 when a < b as unsigned numbers and r = 0 otherwise.
- R7: Code 1000 gives r = {b[15:0], 16'h0000}. Operand `a` has no effect.
- R8: Code 1110 shifts b left and code 1101 shifts b right, both logically and filling with zeros. The distance is a[4:0], and a[31:5] has no effect.
- R9: Code 1100 shifts b right by a[4:0], and every vacated bit takes the value of b[31].
- R10: The unassigned codes 1001 and 1111 behave exactly like code 0000, for both the result and the flags.
- R11: `zero` is 1 exactly when r equals 0, for every code.
- R12: For add codes (and the unassigned codes), `carry` is the carry out of bit 31. For codes 0001 and 0011 it is the borrow, meaning 1 when a < b unsigned. For every other code it is 0. `negative` always equals r[31].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 32 | First operand; supplies the shift distance for shift codes |
| b | input | 32 | Second operand; the data for shift and upper-immediate codes |
| op | input | 4 | Operation code |
| r | output | 32 | Result |
| zero | output | 1 | Result is all zeros |
| carry | output | 1 | Carry out (add) or borrow (subtract) |
| negative | output | 1 | Copy of r[31] |
| overflow | output | 1 | Signed overflow for the signed add and subtract codes |

## Verification
Several flags can be raised by the same operation. The sharpest case is a signed add that overflows and wraps to exactly zero. Adding 0x80000000 to itself under code 0010 raises `overflow`, `carry` and `zero` together and clears `negative`. The same operands under code 0000 must give the same result and carry but no overflow. These coincidences are provoked with directed operands, and the reference model in the scoreboard judges each one alongside random operands for every code.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADDU = 4'b0000,
        OP_SUBU = 4'b0001,
        OP_ADD  = 4'b0010,
        OP_SUB  = 4'b0011,
        OP_AND  = 4'b0100,
        OP_OR   = 4'b0101,
        OP_XOR  = 4'b0110,
        OP_NOR  = 4'b0111,
        OP_LUI  = 4'b1000,
        OP_SLTU = 4'b1010,
        OP_SLT  = 4'b1011,
        OP_SRA  = 4'b1100,
        OP_SRL  = 4'b1101,
        OP_SLL  = 4'b1110
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT      = 2'b00,
        SH_RIGHT_LOG = 2'b01,
        SH_RIGHT_ARI = 2'b10
    } shift_mode_e;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_XOR = 2'b10,
        LG_NOR = 2'b11
    } logic_sel_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
        sum_o  = full[W-1:0];
        cout_o = full[W];
        ovf_o  = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
    end

    // Subtracting an operand from itself must give zero with no borrow or overflow
    always_comb begin
        if (sub_i && (a_i == b_i)) begin
            assert_self_sub_zero_R2: assert (sum_o == '0 && cout_o && !ovf_o);
        end
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]         data_i,
    input  logic [$clog2(W)-1:0] amt_i,
    input  shift_mode_e          mode_i,
    output logic [W-1:0]         res_o
);
    localparam int SW = $clog2(W);

    logic         fill;
    logic [W-1:0] cur;

    always_comb begin
        fill = (mode_i == SH_RIGHT_ARI) && data_i[W-1];
        cur  = data_i;
        for (int k = 0; k < SW; k++) begin
            if (amt_i[k]) begin
                if (mode_i == SH_LEFT) begin
                    cur = cur << (1 << k);
                end else begin
                    cur = (cur >> (1 << k)) |
                          (fill ? ~({W{1'b1}} >> (1 << k)) : {W{1'b0}});
                end
            end
        end
        res_o = cur;
    end

    always_comb begin
        if (amt_i == '0) begin
            assert_zero_dist_pass_R8: assert (res_o == data_i);
        end
        if (mode_i == SH_RIGHT_LOG && amt_i != '0) begin
            assert_log_right_msb_clear_R8: assert (res_o[W-1] == 1'b0);
        end
        if (mode_i == SH_RIGHT_ARI) begin
            assert_ari_sign_kept_R9: assert (res_o[W-1] == data_i[W-1]);
        end
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_sel_e   sel_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (sel_i)
            LG_AND:  res_o = a_i & b_i;
            LG_OR:   res_o = a_i | b_i;
            LG_XOR:  res_o = a_i ^ b_i;
            LG_NOR:  res_o = ~(a_i | b_i);
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       op,
    output logic [WIDTH-1:0] r,
    output logic             zero,
    output logic             carry,
    output logic             negative,
    output logic             overflow
);
    localparam int HALF = WIDTH / 2;
    localparam int SHW  = $clog2(WIDTH);

    alu_op_e      op_e;
    logic         use_sub;
    logic [WIDTH-1:0] sum;
    logic         cout;
    logic         ovf_raw;
    logic [WIDTH-1:0] sh_res;
    logic [WIDTH-1:0] lg_res;
    shift_mode_e  sh_mode;
    logic_sel_e   lg_sel;
    logic         lt_signed;
    logic         lt_unsigned;

    always_comb begin
        op_e    = alu_op_e'(op);
        use_sub = (op_e == OP_SUBU) || (op_e == OP_SUB) ||
                  (op_e == OP_SLT)  || (op_e == OP_SLTU);
        sh_mode = (op_e == OP_SLL) ? SH_LEFT :
                  (op_e == OP_SRA) ? SH_RIGHT_ARI : SH_RIGHT_LOG;
        lg_sel  = logic_sel_e'(op[1:0]);
    end

    alu_addsub #(.W(WIDTH)) u_addsub (
        .a_i(a), .b_i(b), .sub_i(use_sub),
        .sum_o(sum), .cout_o(cout), .ovf_o(ovf_raw)
    );

    alu_shifter #(.W(WIDTH)) u_shifter (
        .data_i(b), .amt_i(a[SHW-1:0]), .mode_i(sh_mode), .res_o(sh_res)
    );

    alu_logic #(.W(WIDTH)) u_logic (
        .a_i(a), .b_i(b), .sel_i(lg_sel), .res_o(lg_res)
    );

    // signed compare uses sign xor overflow of a - b
    assign lt_signed   = sum[WIDTH-1] ^ ovf_raw;
    assign lt_unsigned = ~cout;

    always_comb begin
        r     = sum;
        carry = 1'b0;
        unique case (op_e)
            OP_ADDU, OP_ADD: begin
                r     = sum;
                carry = cout;
            end
            OP_SUBU, OP_SUB: begin
                r     = sum;
                carry = ~cout;
            end
            OP_AND, OP_OR, OP_XOR, OP_NOR: r = lg_res;
            OP_LUI:  r = {b[HALF-1:0], {HALF{1'b0}}};
            OP_SLTU: r = {{(WIDTH-1){1'b0}}, lt_unsigned};
            OP_SLT:  r = {{(WIDTH-1){1'b0}}, lt_signed};
            OP_SRA, OP_SRL, OP_SLL: r = sh_res;
            default: begin
                r     = sum;
                carry = cout;
            end
        endcase
        zero     = (r == '0);
        negative = r[WIDTH-1];
        overflow = ovf_raw && ((op_e == OP_ADD) || (op_e == OP_SUB));
    end

    always_comb begin
        if (overflow) begin
            assert_ovf_only_signed_R3: assert (op == 4'b0010 || op == 4'b0011);
        end
        if (op_e == OP_LUI) begin
            assert_lui_low_clear_R7: assert (r[HALF-1:0] == '0);
        end
        if (op_e == OP_SLT || op_e == OP_SLTU) begin
            assert_compare_is_bit_R5: assert (r[WIDTH-1:1] == '0 && !carry);
        end
        if (op_e == OP_SLT && a == b) begin
            assert_slt_equal_false_R5: assert (r == '0);
        end
    end
endmodule

// File: tb/test_int_alu.sv
module test_int_alu;

    typedef struct {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] r;
        logic        z;
        logic        c;
        logic        n;
        logic        v;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [3:0]  op = '0;
    logic [31:0] r;
    logic        zero, carry, negative, overflow;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    int_alu i_int_alu (
        .a(a), .b(b), .op(op), .r(r),
        .zero(zero), .carry(carry), .negative(negative), .overflow(overflow)
    );

    function automatic item_t model(logic [3:0] o, logic [31:0] x, logic [31:0] y, string tag);
        item_t e;
        logic [32:0] s;
        e.op = o; e.a = x; e.b = y; e.tag = tag;
        e.c = 1'b0; e.v = 1'b0;
        case (o)
            4'd1, 4'd3: begin   // R2, R12 borrow, R3
                e.r = x - y;
                e.c = (x < y);
                e.v = (o == 4'd3) && (x[31] != y[31]) && (e.r[31] != x[31]);
            end
            4'd4: e.r = x & y;                                   // R4
            4'd5: e.r = x | y;
            4'd6: e.r = x ^ y;
            4'd7: e.r = ~(x | y);
            4'd8: e.r = {y[15:0], 16'h0000};                     // R7
            4'd10: e.r = (x < y) ? 32'd1 : 32'd0;                // R6
            4'd11: e.r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0; // R5
            4'd12: e.r = $unsigned($signed(y) >>> x[4:0]);       // R9
            4'd13: e.r = y >> x[4:0];                            // R8
            4'd14: e.r = y << x[4:0];                            // R8
            default: begin      // R1, R10
                s = {1'b0, x} + {1'b0, y};
                e.r = s[31:0];
                e.c = s[32];
                e.v = (o == 4'd2) && (x[31] == y[31]) && (e.r[31] != x[31]);
            end
        endcase
        e.z = (e.r == 32'd0);   // R11
        e.n = e.r[31];          // R12
        return e;
    endfunction

    task automatic send(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y, input string tag);
        @(negedge clk);
        op = o; a = x; b = y;
        q.push_back(model(o, x, y, tag));
    endtask

    // monitor: results are settled by the following rising edge
    always @(posedge clk) begin
        if (rst_n && q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            checks++;
            if (r !== e.r || zero !== e.z || carry !== e.c ||
                negative !== e.n || overflow !== e.v) begin
                errors++;
                $display("FAIL %s op=%b a=%h b=%h: actual r=%h z%b c%b n%b v%b expected r=%h z%b c%b n%b v%b",
                         e.tag, e.op, e.a, e.b, r, zero, carry, negative, overflow,
                         e.r, e.z, e.c, e.n, e.v);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual not finished, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state: all-zero inputs
        send(4'd0, 32'h0, 32'h0, "R11 idle");
        // R1
        send(4'd0, 32'h0000_1234, 32'h0000_4321, "R1 addu");
        send(4'd2, 32'hFFFF_FFFF, 32'h0000_0001, "R1 add wrap carry");
        // R3 with R11 and R12: overflow, carry and zero together
        send(4'd2, 32'h8000_0000, 32'h8000_0000, "R3 add ovf zero");
        send(4'd0, 32'h8000_0000, 32'h8000_0000, "R3 addu no ovf");
        send(4'd2, 32'h7FFF_FFFF, 32'h0000_0001, "R3 add pos ovf");
        send(4'd3, 32'h8000_0000, 32'h0000_0001, "R3 sub ovf");
        send(4'd1, 32'h8000_0000, 32'h0000_0001, "R3 subu no ovf");
        // R2
        send(4'd1, 32'h0000_0005, 32'h0000_0007, "R2 subu borrow");
        send(4'd3, 32'h0000_0009, 32'h0000_0009, "R2 sub equal");
        // R4
        send(4'd4, 32'hF0F0_F0F0, 32'hFF00_FF00, "R4 and");
        send(4'd5, 32'hF0F0_F0F0, 32'h0F00_FF00, "R4 or");
        send(4'd6, 32'hAAAA_5555, 32'hFFFF_0000, "R4 xor");
        send(4'd7, 32'h0000_0000, 32'h0000_0000, "R4 nor all ones");
        // R5 extremes
        send(4'd11, 32'h8000_0000, 32'h7FFF_FFFF, "R5 min lt max");
        send(4'd11, 32'h7FFF_FFFF, 32'h8000_0000, "R5 max not lt min");
        send(4'd11, 32'hFFFF_FFFF, 32'h0000_0000, "R5 minus one lt zero");
        // R6
        send(4'd10, 32'hFFFF_FFFF, 32'h0000_0000, "R6 unsigned big");
        send(4'd10, 32'h0000_0001, 32'h8000_0000, "R6 unsigned lt");
        // R7
        send(4'd8, 32'hDEAD_BEEF, 32'h1234_ABCD, "R7 lui");
        send(4'd8, 32'h0000_0000, 32'h1234_ABCD, "R7 lui other a");
        // R8: upper bits of a ignored
        send(4'd14, 32'hFFFF_FFE4, 32'h0000_0001, "R8 sll 4 upper a");
        send(4'd13, 32'h0000_001F, 32'h8000_0000, "R8 srl 31");
        send(4'd13, 32'h0000_0020, 32'h8000_0000, "R8 srl dist 0");
        // R9
        send(4'd12, 32'h0000_0004, 32'h8000_0000, "R9 sra neg");
        send(4'd12, 32'h0000_001F, 32'h7FFF_FFFF, "R9 sra pos");
        // R10
        send(4'd9,  32'hFFFF_FFFF, 32'h0000_0002, "R10 code 1001");
        send(4'd15, 32'h8000_0000, 32'h8000_0000, "R10 code 1111");
        // random sweep over all codes
        for (int i = 0; i < 1600; i++) begin
            send(4'(i % 16), $urandom, $urandom, "R12 random");
        end
        wait (q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule